// File: doc/BRIEF.md
# Subroutine Call Program Counter Unit

This unit keeps the program counter of a small 8-bit microcontroller core together with a hardware stack of return addresses. Each cycle, a decoded instruction strobe asks it to do one of three things: step to the next instruction, call a subroutine, or return from one. A call takes its target from two sources. An 11-bit immediate fills the low part of the counter, and two page bits come from a separate 5-bit page-latch register.

Calls and returns are two-cycle instructions. In the cycle after either one is accepted, the unit raises `stall`. In that cycle the core treats its slot as a no-operation while it fetches from the new address. The unit ignores every strobe during that cycle.

The return stack holds eight entries and is circular. A ninth nested call silently overwrites the oldest entry, and no overflow or underflow flag exists. No status flags change on a call.

Top module: `call_pc_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, `pc` reads 0 and `stall` reads 0. The stack pointer is at its first entry, and all entries hold 0, so a return with nothing pushed loads 0.
- R2: When `adv` is the only strobe accepted, `pc` becomes `pc+1` modulo 8192 on the next cycle, so 8191 wraps to 0.
- R3: An accepted `call` sets `pc` on the next cycle. Bits 10..0 take `imm`, and bits 12..11 take `page_latch[4:3]`. Bits 2..0 of `page_latch` are unused.
- R4: An accepted `call` pushes `pc+1` modulo 8192. This is the address after the calling instruction, so a call at 8191 stores 0.
- R5: The cycle after an accepted `call` or `ret` has `stall` high for exactly one cycle. During that cycle `pc` holds its value and any `adv`, `call` or `ret` is ignored.
- R6: An accepted `ret` loads all 13 bits of `pc` from the top stack entry and pops it. The value of `page_latch` has no effect on a return.
- R7: Up to eight nested calls return in last-in, first-out order.
- R8: The stack is an 8-entry circular buffer. After nine pushes, the ninth overwrites the first. Nine pops then return the ninth address, the eighth down to the second, and the ninth again.
- R9: When several strobes are high outside a stall, `call` wins over `ret`, and `ret` wins over `adv`.
- R10: With no strobe high and no stall, `pc` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv | input | 1 | Step to the next instruction |
| call | input | 1 | Subroutine call strobe |
| ret | input | 1 | Return strobe |
| imm | input | 11 | Call target, low bits |
| page_latch | input | 5 | Page latch; bits 4..3 give the call page |
| pc | output | 13 | Current program counter |
| stall | output | 1 | Second cycle of a call or return |

## Verification
A wrong stack pointer or a corrupted entry is invisible until a return. It then shows up on `pc` one cycle after the `ret` is accepted, as a wrong address. For that reason every call in the sweep is paired with a return, and the nesting tests drain the stack completely, including past its wrap.

A mistimed `stall` shows up within one cycle: `pc` moves when it should hold, or a strobe issued in the no-operation slot takes effect. Each stall cycle is therefore driven with all strobes high.

// File: rtl/call_pc_unit.sv
module call_pc_unit #(
  parameter int PC_W    = 13,
  parameter int IMM_W   = 11,
  parameter int LATCH_W = 5,
  parameter int PG_LSB  = 3,
  parameter int DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               call,
  input  logic               ret,
  input  logic [IMM_W-1:0]   imm,
  input  logic [LATCH_W-1:0] page_latch,
  output logic [PC_W-1:0]    pc,
  output logic               stall
);
  localparam int PG_W = PC_W - IMM_W;
  localparam int SP_W = $clog2(DEPTH);

  logic [PC_W-1:0] stk [DEPTH];
  logic [SP_W-1:0] sp;

  wire take_call = call & ~stall;
  wire take_ret  = ret & ~stall & ~call;
  wire take_adv  = adv & ~stall & ~call & ~ret;
  wire [SP_W-1:0] sp_top  = sp - 1'b1;
  wire [PC_W-1:0] pc_next = pc + 1'b1;
  wire [PC_W-1:0] target  = {page_latch[PG_LSB +: PG_W], imm};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      stall <= 1'b0;
      sp    <= '0;
    end else begin
      stall <= take_call | take_ret;
      if (take_call) begin
        pc <= target;
        sp <= sp + 1'b1;
      end else if (take_ret) begin
        pc <= stk[sp_top];
        sp <= sp_top;
      end else if (take_adv) begin
        pc <= pc_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (take_call) begin
      stk[sp] <= pc_next;
    end
  end

  // R5
  stall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
  // R5
  stall_after_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((call || ret) && !stall) |=> stall);
  // R5
  pc_hold_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc));
  // R3
  call_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call && !stall) |=> (pc == {$past(page_latch[PG_LSB +: PG_W]), $past(imm)}));
  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !call && !ret && !stall) |=> (pc == $past(pc) + 1'b1));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !call && !ret && !stall) |=> $stable(pc));
endmodule

// File: tb/call_pc_unit_tb.sv
module call_pc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv = 1'b0, call = 1'b0, ret = 1'b0;
  logic [10:0] imm = '0;
  logic [4:0]  page_latch = '0;
  logic [12:0] pc;
  logic        stall;

  int n_chk = 0;
  int n_bad = 0;

  logic [12:0] m_pc;
  logic        m_stall;
  logic [12:0] m_stk [8];
  int          m_sp;

  always #5 clk = ~clk;

  call_pc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .adv(adv), .call(call), .ret(ret),
    .imm(imm), .page_latch(page_latch), .pc(pc), .stall(stall)
  );

  task automatic check(input string tag, input logic [12:0] exp_pc, input logic exp_st);
    n_chk++;
    if (pc !== exp_pc || stall !== exp_st) begin
      n_bad++;
      $display("FAIL %s: pc=%0d stall=%0b expected pc=%0d stall=%0b", tag, pc, stall, exp_pc, exp_st);
    end
  endtask

  task automatic step(input logic a, input logic c, input logic r,
                      input logic [10:0] im, input logic [4:0] lt, input string tag);
    @(negedge clk);
    adv = a; call = c; ret = r; imm = im; page_latch = lt;
    if (m_stall) m_stall = 1'b0;
    else if (c) begin
      m_stk[m_sp] = 13'((m_pc + 1) % 8192);
      m_sp = (m_sp + 1) % 8;
      m_pc = {lt[4:3], im};
      m_stall = 1'b1;
    end else if (r) begin
      m_sp = (m_sp + 7) % 8;
      m_pc = m_stk[m_sp];
      m_stall = 1'b1;
    end else if (a) m_pc = 13'((m_pc + 1) % 8192);
    @(posedge clk); #1;
    check(tag, m_pc, m_stall);
  endtask

  task automatic do_call(input logic [10:0] im, input logic [4:0] lt, input string tag);
    step(0, 1, 0, im, lt, tag);
    step(1, 1, 1, ~im, ~lt, "R5 stall ignores strobes");
  endtask

  task automatic do_ret(input logic [4:0] lt, input string tag);
    step(0, 0, 1, 11'h555, lt, tag);
    step(1, 1, 1, 11'h2aa, ~lt, "R5 stall ignores strobes");
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_pc = '0; m_stall = 1'b0; m_sp = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    #1;
    check("R1 in reset", 13'd0, 1'b0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", 13'd0, 1'b0);
    // R1: return with empty stack loads 0
    step(1, 0, 0, 0, 0, "R2 first advance");
    do_ret(5'h1f, "R1 empty return");

    // R2: full advance sweep including wrap
    for (int i = 0; i < 8200; i++) step(1, 0, 0, 11'(i), 5'(i), "R2 advance");
    // R10: idle holds
    for (int i = 0; i < 5; i++) step(0, 0, 0, 11'(i), 5'(i), "R10 idle");

    // R3 R4 R6: every immediate on every page, with a return after each
    for (int pg = 0; pg < 4; pg++)
      for (int k = 0; k < 2048; k++) begin
        do_call(11'(k), {2'(pg), 3'(k)}, "R3 call target");
        do_ret({2'(3 - pg), 3'(~k)}, "R6 return ignores latch");
        step(1, 0, 0, 0, 0, "R2 advance after return");
      end

    // R4: call at 8191 pushes 0
    do_call(11'h7ff, 5'b11000, "R3 call to 8191");
    do_call(11'h010, 5'b00000, "R4 call from 8191");
    do_ret(5'b11111, "R4 return wraps to 0");
    do_ret(5'b00000, "R4 outer return");

    // R9: priority
    step(1, 1, 1, 11'h123, 5'b01000, "R9 call beats ret and adv");
    step(0, 0, 0, 0, 0, "R5 stall clears");
    step(1, 0, 1, 11'h321, 5'b10000, "R9 ret beats adv");
    step(0, 0, 0, 0, 0, "R5 stall clears");

    // R7: nested to depth 8
    for (int i = 0; i < 8; i++) begin
      do_call(11'(100 * i + 7), 5'(i * 8), "R7 nested call");
      step(1, 0, 0, 0, 0, "R2 advance in callee");
    end
    for (int i = 0; i < 8; i++) do_ret(5'(i), "R7 LIFO return");

    // R8: ninth push overwrites oldest; nine pops wrap back
    for (int i = 0; i < 9; i++) do_call(11'(200 + i * 3), 5'(i * 8), "R8 push");
    for (int i = 0; i < 10; i++) do_ret(5'(i), "R8 circular pop");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule